// File: doc/BRIEF.md
# Boot-Remappable Chip-Select Decoder

This block turns a 32-bit system address into one-hot select lines for an embedded SoC memory map. The upper nibble of the address picks one of sixteen 256 MB regions, and each populated region has its own chip select. For the external regions the block also reports the data-bus width. Inside the I/O region it flags the block of AHB-mapped registers, and within that block it flags a 16 KB on-chip boot ROM, giving the 14-bit offset into the ROM.

After reset the decoder runs in boot mode. In this mode the boot ROM is mirrored at every 16 KB step across the whole 4 GB space. Any valid access selects the ROM, using the low 14 address bits as the offset. The first instructions can therefore be fetched no matter where the processor starts. A single-cycle remap pulse from software leaves boot mode for good, and the normal physical map takes over. Only reset brings boot mode back. All decode outputs are combinational from the address and are qualified by the access-valid strobe.

Top module: `boot_cs_decoder`

## Requirements
- R1: Reset (active-low, asynchronous) enters boot mode. In boot mode every valid access asserts `rom_sel` with `rom_offset` = addr[13:0], and leaves `chip_sel`, `bus_width`, `ahb_reg_sel` and `dec_err` at zero.
- R2: A remap pulse leaves boot mode starting with the cycle after the clock edge that samples it. An access in the same cycle as the pulse is still decoded in boot mode.
- R3: Outside reset, nothing re-enters boot mode. Further remap pulses leave the normal decode unchanged.
- R4: Outside boot mode, a valid access to region r = addr[31:28] with r in {0, 1, 2, 6, 7, 8} asserts exactly bit r of `chip_sel`.
- R5: `bus_width` is 2'b10 (32-bit) for region 0, 2'b00 (8-bit) for region 1, and 2'b01 (16-bit) for regions 2, 6 and 7. It is 2'b00 whenever no external select (regions 0, 1, 2, 6, 7) is active.
- R6: Outside boot mode, `ahb_reg_sel` is high exactly for valid addresses 0x80000000–0x807FFFFF.
- R7: Outside boot mode, `rom_sel` is high exactly for valid addresses 0x80090000–0x80093FFF, with `rom_offset` = addr[13:0]. Otherwise `rom_offset` is zero.
- R8: Outside boot mode, a valid access to regions 0x3–0x5 or 0x9–0xF asserts `dec_err` and no chip select.
- R9: When `acc_valid` is low, every decode output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boot-mode flag |
| rst_n | input | 1 | Asynchronous active-low reset; enters boot mode |
| addr | input | 32 | System address to decode |
| acc_valid | input | 1 | Access strobe qualifying all outputs |
| remap_pulse | input | 1 | One-cycle request to leave boot mode |
| chip_sel | output | 16 | One-hot region select, bit index = addr[31:28] |
| bus_width | output | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit |
| ahb_reg_sel | output | 1 | AHB-mapped register block selected |
| rom_sel | output | 1 | Boot ROM selected |
| rom_offset | output | 14 | Byte offset into the boot ROM |
| dec_err | output | 1 | Access to an unpopulated region |

## Verification
The in-RTL assertions check several properties on every cycle. The region selects stay one-hot, and a select never coincides with a decode error. A width code appears only while an external select is active. An idle strobe leaves every output quiet. Once the boot flag has cleared it stays clear, and a remap pulse always clears it. Other behaviour is visible only in the bench's scenarios, which compare each cycle against a behavioural model. These include the exact address limits of the AHB window and the ROM window, the per-region width codes, and the fact that an access in the remap cycle is still aliased. They also show that boot mode comes back only through a fresh reset.

// File: rtl/boot_cs_decoder.sv
module boot_cs_decoder #(
  parameter int          ROM_AW    = 14,
  parameter int          AHB_AW    = 23,
  parameter logic [31:0] ROM_BASE  = 32'h8009_0000,
  parameter logic [31:0] AHB_BASE  = 32'h8000_0000,
  parameter logic [15:0] CS_MAP    = 16'h01C7,
  parameter logic [15:0] EXT_MAP   = 16'h00C7,
  parameter logic [31:0] WIDTH_MAP = 32'h0000_5012
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       addr,
  input  logic              acc_valid,
  input  logic              remap_pulse,
  output logic [15:0]       chip_sel,
  output logic [1:0]        bus_width,
  output logic              ahb_reg_sel,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_offset,
  output logic              dec_err
);
  localparam int REGIONS = 16;
  localparam int RW      = 4;

  logic          boot_q;
  logic [RW-1:0] region;
  logic          normal_hit;
  logic          ext_hit;
  logic          rom_win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           boot_q <= 1'b1;
    else if (remap_pulse) boot_q <= 1'b0;

  assign region     = addr[31:32-RW];
  assign normal_hit = acc_valid && !boot_q;
  assign ext_hit    = normal_hit && EXT_MAP[region];
  assign rom_win    = addr[31:ROM_AW] == ROM_BASE[31:ROM_AW];

  for (genvar g = 0; g < REGIONS; g++) begin : g_cs
    if (CS_MAP[g]) begin : g_pop
      assign chip_sel[g] = normal_hit && (region == RW'(g));
    end else begin : g_empty
      assign chip_sel[g] = 1'b0;
    end
  end

  assign bus_width   = ext_hit ? WIDTH_MAP[{region, 1'b0} +: 2] : 2'b00;
  assign ahb_reg_sel = normal_hit && (addr[31:AHB_AW] == AHB_BASE[31:AHB_AW]);
  assign rom_sel     = acc_valid && (boot_q || rom_win);
  assign rom_offset  = rom_sel ? addr[ROM_AW-1:0] : '0;
  assign dec_err     = normal_hit && !CS_MAP[region];

  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chip_sel));
  assert_err_no_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (chip_sel == 16'h0));
  assert_width_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_width != 2'b00) |-> ((chip_sel & EXT_MAP) != 16'h0));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (chip_sel == 16'h0 && !rom_sel && !ahb_reg_sel && !dec_err));
  assert_boot_alias_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_q && acc_valid) |-> (rom_sel && chip_sel == 16'h0 && !dec_err));
  assert_remap_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |=> !boot_q);
  assert_no_reenter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q);
endmodule

// File: tb/boot_cs_decoder_tb.sv
module boot_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        acc_valid = 1'b0;
  logic        remap_pulse = 1'b0;
  logic [15:0] chip_sel;
  logic [1:0]  bus_width;
  logic        ahb_reg_sel, rom_sel, dec_err;
  logic [13:0] rom_offset;

  int checks = 0, fails = 0, cycles = 0;
  bit model_boot = 1'b1;
  string cur_req = "R1";

  always #5 clk = ~clk;

  boot_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .acc_valid(acc_valid),
    .remap_pulse(remap_pulse), .chip_sel(chip_sel), .bus_width(bus_width),
    .ahb_reg_sel(ahb_reg_sel), .rom_sel(rom_sel), .rom_offset(rom_offset),
    .dec_err(dec_err)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_boot <= 1'b1;
    else if (remap_pulse) model_boot <= 1'b0;

  task automatic compare();
    int r;
    logic [15:0] e_cs = '0;
    logic [1:0]  e_w = 2'b00;
    logic        e_ahb = 0, e_rom = 0, e_err = 0;
    logic [13:0] e_off = '0;
    r = int'(addr >> 28);
    if (acc_valid) begin
      if (model_boot) begin
        e_rom = 1; e_off = addr[13:0];
      end else begin
        case (r)
          0: begin e_cs[0] = 1; e_w = 2'b10; end
          1: begin e_cs[1] = 1; e_w = 2'b00; end
          2: begin e_cs[2] = 1; e_w = 2'b01; end
          6: begin e_cs[6] = 1; e_w = 2'b01; end
          7: begin e_cs[7] = 1; e_w = 2'b01; end
          8: e_cs[8] = 1;
          default: e_err = 1;
        endcase
        e_ahb = (addr >= 32'h8000_0000) && (addr <= 32'h807F_FFFF);
        if (addr >= 32'h8009_0000 && addr <= 32'h8009_3FFF) begin
          e_rom = 1; e_off = addr[13:0];
        end
      end
    end
    checks++;
    if (chip_sel !== e_cs || bus_width !== e_w || ahb_reg_sel !== e_ahb ||
        rom_sel !== e_rom || rom_offset !== e_off || dec_err !== e_err) begin
      fails++;
      $display("FAIL %s addr=%h act cs=%h w=%b ahb=%b rom=%b off=%h err=%b exp cs=%h w=%b ahb=%b rom=%b off=%h err=%b",
               cur_req, addr, chip_sel, bus_width, ahb_reg_sel, rom_sel, rom_offset, dec_err,
               e_cs, e_w, e_ahb, e_rom, e_off, e_err);
    end
  endtask

  always @(negedge clk) begin
    #2 compare();
  end

  task automatic step(input logic [31:0] a, input logic v, input logic rp, input string req);
    @(negedge clk);
    addr = a; acc_valid = v; remap_pulse = rp; cur_req = req;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d expected<=5000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    step(32'h1234_5678, 0, 0, "R9");
    step(32'h0000_0ABC, 1, 0, "R1");
    step(32'h0000_0000, 1, 0, "R1");
    rst_n = 1'b1;
    step(32'hFFFF_FFFF, 1, 0, "R1");
    step(32'h8009_0004, 1, 0, "R1");
    step(32'h3000_7FFF, 1, 0, "R1");
    step(32'h0000_1234, 1, 1, "R2");
    step(32'h0000_1234, 1, 0, "R2");
    for (int r = 0; r < 16; r++) begin
      step((r << 28) | 32'h00AB_CDEF, 1, 0, "R4_R5_R8");
      step((r << 28) | 32'h0FFF_FFFF, 1, 0, "R4_R5_R8");
    end
    step(32'h8000_0000, 1, 0, "R6");
    step(32'h807F_FFFF, 1, 0, "R6");
    step(32'h8080_0000, 1, 0, "R6");
    step(32'h8008_FFFF, 1, 0, "R7");
    step(32'h8009_0000, 1, 0, "R7");
    step(32'h8009_3FFF, 1, 0, "R7");
    step(32'h8009_4000, 1, 0, "R7");
    step(32'h0009_0010, 1, 0, "R7");
    step(32'h8009_0010, 0, 0, "R9");
    step(32'h0000_0000, 0, 0, "R9");
    step(32'h0000_0010, 1, 1, "R3");
    step(32'h0000_0010, 1, 0, "R3");
    step(32'h2000_0010, 1, 1, "R3");
    step(32'h6000_0010, 1, 0, "R3");
    @(negedge clk);
    rst_n = 1'b0; cur_req = "R1";
    step(32'h7000_0044, 1, 0, "R1");
    rst_n = 1'b1;
    step(32'h1000_2222, 1, 0, "R1");
    step(32'h1000_2222, 1, 1, "R2");
    step(32'h1000_2222, 1, 0, "R2");
    @(negedge clk);
    #4;
    finish_run();
  end
endmodule